// File: doc/BRIEF.md
# Multiplexed Packet Bus Master Sequencer

This block is the processor-side controller for a 16-bit bus that carries address, transfer specification and data on the same lines. A client hands it one access at a time: direction, atomic flag, target class, a length code, a two-bit modifier, a 24-bit byte address and up to five double-bytes of write data. The block then walks the bus through an idle state, a request cycle, an upper-address cycle, one data cycle per double-byte, optional wait cycles and a closing recovery cycle. It drives the shared lines, a request strobe and a buffer-direction output, and it reads a single status input whose meaning depends on the cycle.

An access may be withdrawn during its request cycle. The block then raises the strobe again in the address cycle and the slave drops it. When a write is finishing and the client already offers another write, the recovery cycle is replaced by an overlapped request cycle for the new access. Completion, cancellation and errors come back as a one-cycle response pulse. For reads this pulse comes with the assembled data.

Top module: `pkt_bus_master`

## Requirements
- R1: After reset the block is idle: request strobe low, shared lines released, direction output low, no response pulse, and a request is accepted (ready high).
- R2: In the request cycle (normal or overlapped) the strobe and direction output are high, and the lines carry the specification byte in bits 15:8 and address bits 7:0 in bits 7:0. The specification byte places the class flag (0 memory, 1 other) at bit 15, direction (1 write) at bit 14, the atomic flag at bit 13, the length code at bits 12:10 and the modifier at bits 9:8.
- R3: The cycle after a request cycle carries address bits 23:16 in line bits 15:8 and address bits 15:8 in line bits 7:0, with the lines driven and the direction output high.
- R4: In the address, data and wait cycles, a low status input leads to a wait cycle. A high status input leads to a data cycle. A wait cycle repeats the outputs of the data cycle it precedes, with the strobe low.
- R5: Length codes 0..5 transfer 1, 1, 2, 3, 4 and 5 double-bytes, one data cycle each. For writes the lines carry write-data double-byte k (request bits 16k+15:16k) in data cycle k and its waits, with the direction output high.
- R6: For reads the lines are released and the direction output is low in data and wait cycles. The value on the lines in data cycle k is returned in response bits 16k+15:16k, and slots beyond the length read as zero.
- R7: After the last data cycle the block spends one recovery cycle with the lines released and the strobe and direction output low. The response pulse follows in the next cycle and lasts one cycle.
- R8: A high status input during the recovery cycle (plain or overlapped) is reported as an error flag with that access's response pulse.
- R9: Abort held high in the request cycle raises the strobe in the following address cycle. No data cycle follows, and a response pulse with the cancel flag comes next. The block then goes to a new request cycle if it accepted a legal request in the address cycle, and to idle otherwise.
- R10: When a write is in its last data cycle and a legal write request is offered, the request is accepted. The next cycle is an overlapped request cycle for it, followed by its address cycle, in which the previous write's response pulse appears.
- R11: A request with length code 6 or 7 is accepted only when idle. It produces a response pulse with the error flag in the next cycle, starts no bus cycle and leaves the block idle.
- R12: A legal request offered during a recovery cycle is accepted, and the next cycle is its request cycle.
- R13: Ready is low in request cycles, uncancelled address cycles, wait cycles and data cycles other than the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid_i | input | 1 | Client offers an access |
| req_ready_o | output | 1 | Offered access is taken this cycle |
| req_other_i | input | 1 | Target class: 0 memory, 1 other |
| req_write_i | input | 1 | 1 write, 0 read |
| req_rmw_i | input | 1 | Atomic read-modify-write flag |
| req_len_i | input | 3 | Length code |
| req_mode_i | input | 2 | Access modifier |
| req_addr_i | input | 24 | Byte address |
| req_wdata_i | input | 80 | Write data, lowest double-byte first |
| req_abort_i | input | 1 | Withdraw the access in its request cycle |
| rsp_done_o | output | 1 | One-cycle response pulse |
| rsp_err_o | output | 1 | Error flag with the pulse |
| rsp_cancel_o | output | 1 | Cancel flag with the pulse |
| rsp_rdata_o | output | 80 | Assembled read data |
| bus_acd_o | output | 16 | Shared line output value |
| bus_acd_oe_o | output | 1 | Shared line output enable |
| bus_acd_i | input | 16 | Shared line input value |
| bus_prq_o | output | 1 | Request strobe |
| bus_bout_o | output | 1 | External buffer direction, high when driving out |
| bus_ics_i | input | 1 | Status input (wait control, error) |

## Verification
The assertions check on every cycle that the lines stay released in idle, recovery and read data cycles. They also check that a wait cycle holds its outputs, that request cycles lead to address cycles, and that cancels, overlapped starts, rejections and recoveries produce a response pulse on time. The exact line contents only show up in the bench's scenarios: specification bits, address slices and write double-bytes in order. The same holds for how read data assembles across waits, how errors and cancel flags attach to the right access, and back-to-back and overlapped sequences under random wait patterns.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

  localparam int unsigned PBM_ADDR_W = 24;
  localparam int unsigned PBM_DB_W   = 16;

  typedef enum logic [2:0] {
    ST_IDLE,   // bus idle
    ST_FIRST,  // request cycle
    ST_ADDR,   // upper address cycle
    ST_XFER,   // data double-byte
    ST_WAIT,   // stretched data
    ST_REC,    // recovery
    ST_OVL     // overlapped request cycle
  } bus_state_e;

  typedef struct packed {
    logic       other;
    logic       write;
    logic       rmw;
    logic [2:0] len;
    logic [1:0] mode;
  } spec_t;

  // number of double-byte data cycles per length code
  function automatic logic [2:0] beats_of(input logic [2:0] len);
    logic [2:0] n;
    case (len)
      3'd0, 3'd1: n = 3'd1;
      3'd2:       n = 3'd2;
      3'd3:       n = 3'd3;
      3'd4:       n = 3'd4;
      3'd5:       n = 3'd5;
      default:    n = 3'd0;
    endcase
    return n;
  endfunction

  function automatic logic len_legal(input logic [2:0] len);
    return (len <= 3'd5);
  endfunction

endpackage

// File: rtl/pbm_rst_sync.sv
module pbm_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/pbm_fsm.sv
module pbm_fsm
  import pbm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       take_i,    // legal request accepted this cycle
  input  logic       cancel_i,  // current access withdrawn
  input  logic       ics_i,
  input  logic       last_i,    // current data cycle is the final one
  output bus_state_e state_o
);
  bus_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  state_d = take_i ? ST_FIRST : ST_IDLE;
      ST_FIRST: state_d = ST_ADDR;
      ST_ADDR: begin
        if (cancel_i)   state_d = take_i ? ST_FIRST : ST_IDLE;
        else            state_d = ics_i ? ST_XFER : ST_WAIT;
      end
      ST_XFER: begin
        if (!last_i)    state_d = ics_i ? ST_XFER : ST_WAIT;
        else            state_d = take_i ? ST_OVL : ST_REC;
      end
      ST_WAIT:  state_d = ics_i ? ST_XFER : ST_WAIT;
      ST_REC:   state_d = take_i ? ST_FIRST : ST_IDLE;
      ST_OVL:   state_d = ST_ADDR;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/pbm_req_regs.sv
module pbm_req_regs
  import pbm_pkg::*;
#(
  parameter int unsigned MAX_DB = 5
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              load_i,
  input  bus_state_e                        state_i,
  input  logic                              abort_i,
  input  spec_t                             spec_i,
  input  logic [PBM_ADDR_W-1:0]             addr_i,
  input  logic [MAX_DB*PBM_DB_W-1:0]        wdata_i,
  output spec_t                             spec_o,
  output logic [PBM_ADDR_W-1:0]             addr_o,
  output logic [MAX_DB*PBM_DB_W-1:0]        wdata_o,
  output logic [$clog2(MAX_DB+1)-1:0]       beat_o,
  output logic                              last_o,
  output logic                              cancel_o
);
  localparam int unsigned DATA_W = MAX_DB * PBM_DB_W;
  localparam int unsigned CNT_W  = $clog2(MAX_DB + 1);

  spec_t                 spec_q;
  logic [PBM_ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0]     wdata_q;
  logic [CNT_W-1:0]      beat_q, nbeat_q;
  logic                  cancel_q;
  logic                  beat_en, cancel_en, cancel_d;

  // access descriptor, written only when a request is taken
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spec_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      nbeat_q <= CNT_W'(1);
    end else if (load_i) begin
      spec_q  <= spec_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      nbeat_q <= CNT_W'(beats_of(spec_i.len));
    end
  end

  assign last_o  = (beat_q == nbeat_q - CNT_W'(1));
  assign beat_en = load_i || ((state_i == ST_XFER) && !last_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      beat_q <= '0;
    else if (beat_en) beat_q <= load_i ? '0 : beat_q + CNT_W'(1);
  end

  // withdrawal is sampled in the request cycle and held through the address cycle
  assign cancel_en = (state_i == ST_FIRST) || (state_i == ST_OVL) || (state_i == ST_ADDR);
  assign cancel_d  = (state_i == ST_ADDR) ? 1'b0 : abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cancel_q <= 1'b0;
    else if (cancel_en) cancel_q <= cancel_d;
  end

  assign spec_o   = spec_q;
  assign addr_o   = addr_q;
  assign wdata_o  = wdata_q;
  assign beat_o   = beat_q;
  assign cancel_o = cancel_q;
endmodule

// File: rtl/pbm_datapath.sv
module pbm_datapath
  import pbm_pkg::*;
#(
  parameter int unsigned MAX_DB = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  bus_state_e                    state_i,
  input  spec_t                         spec_i,
  input  logic [PBM_ADDR_W-1:0]         addr_i,
  input  logic [MAX_DB*PBM_DB_W-1:0]    wdata_i,
  input  logic [$clog2(MAX_DB+1)-1:0]   beat_i,
  input  logic                          cancel_i,
  input  logic                          take_bad_i,
  input  logic                          ics_i,
  input  logic [PBM_DB_W-1:0]           acd_i,
  output logic [PBM_DB_W-1:0]           acd_o,
  output logic                          acd_oe_o,
  output logic                          bout_o,
  output logic                          prq_o,
  output logic [MAX_DB*PBM_DB_W-1:0]    rdata_o,
  output logic                          done_o,
  output logic                          err_o,
  output logic                          cancel_o
);
  localparam int unsigned CNT_W = $clog2(MAX_DB + 1);

  logic [PBM_DB_W-1:0] wword [MAX_DB];
  logic [PBM_DB_W-1:0] slot_q [MAX_DB];
  logic                data_cyc, rec_cyc, cxl_cyc, cap_en;

  for (genvar g = 0; g < MAX_DB; g++) begin : g_word
    assign wword[g] = wdata_i[g*PBM_DB_W +: PBM_DB_W];
    assign rdata_o[g*PBM_DB_W +: PBM_DB_W] = slot_q[g];
  end

  assign data_cyc = (state_i == ST_XFER) || (state_i == ST_WAIT);
  assign rec_cyc  = (state_i == ST_REC)  || (state_i == ST_OVL);
  assign cxl_cyc  = (state_i == ST_ADDR) && cancel_i;

  // bus side, decoded from registered state only
  always_comb begin
    acd_o    = '0;
    acd_oe_o = 1'b0;
    unique case (state_i)
      ST_FIRST, ST_OVL: begin
        acd_o    = {spec_i, addr_i[7:0]};
        acd_oe_o = 1'b1;
      end
      ST_ADDR: begin
        acd_o    = {addr_i[23:16], addr_i[15:8]};
        acd_oe_o = 1'b1;
      end
      ST_XFER, ST_WAIT: begin
        if (spec_i.write) begin
          acd_o    = wword[beat_i];
          acd_oe_o = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign bout_o = (state_i == ST_FIRST) || (state_i == ST_ADDR) || (state_i == ST_OVL) ||
                  (data_cyc && spec_i.write);
  assign prq_o  = (state_i == ST_FIRST) || (state_i == ST_OVL) || cxl_cyc;

  // read assembly: cleared in the request cycle, filled per data cycle
  assign cap_en = (state_i == ST_FIRST) || ((state_i == ST_XFER) && !spec_i.write);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MAX_DB; i++) slot_q[i] <= '0;
    end else if (cap_en) begin
      for (int i = 0; i < MAX_DB; i++) begin
        if (state_i == ST_FIRST)         slot_q[i] <= '0;
        else if (beat_i == CNT_W'(i))    slot_q[i] <= acd_i;
      end
    end
  end

  // response pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      cancel_o <= 1'b0;
    end else begin
      done_o   <= rec_cyc || cxl_cyc || take_bad_i;
      err_o    <= rec_cyc ? ics_i : take_bad_i;
      cancel_o <= cxl_cyc;
    end
  end
endmodule

// File: rtl/pkt_bus_master.sv
module pkt_bus_master
  import pbm_pkg::*;
#(
  parameter int unsigned MAX_DB = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_valid_i,
  output logic                          req_ready_o,
  input  logic                          req_other_i,
  input  logic                          req_write_i,
  input  logic                          req_rmw_i,
  input  logic [2:0]                    req_len_i,
  input  logic [1:0]                    req_mode_i,
  input  logic [PBM_ADDR_W-1:0]         req_addr_i,
  input  logic [MAX_DB*PBM_DB_W-1:0]    req_wdata_i,
  input  logic                          req_abort_i,
  output logic                          rsp_done_o,
  output logic                          rsp_err_o,
  output logic                          rsp_cancel_o,
  output logic [MAX_DB*PBM_DB_W-1:0]    rsp_rdata_o,
  output logic [PBM_DB_W-1:0]           bus_acd_o,
  output logic                          bus_acd_oe_o,
  input  logic [PBM_DB_W-1:0]           bus_acd_i,
  output logic                          bus_prq_o,
  output logic                          bus_bout_o,
  input  logic                          bus_ics_i
);
  localparam int unsigned DATA_W = MAX_DB * PBM_DB_W;
  localparam int unsigned CNT_W  = $clog2(MAX_DB + 1);

  logic                  rst_sync_n;
  bus_state_e            state_q;
  spec_t                 req_spec, spec_q;
  logic [PBM_ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0]     wdata_q;
  logic [CNT_W-1:0]      beat_q;
  logic                  last_beat, cancel_q;
  logic                  len_ok, ready, take, take_good, take_bad;

  assign req_spec = spec_t'({req_other_i, req_write_i, req_rmw_i, req_len_i, req_mode_i});
  assign len_ok   = len_legal(req_len_i);

  // acceptance points: idle, recovery, cancelled address cycle, last write beat
  always_comb begin
    unique case (state_q)
      ST_IDLE: ready = 1'b1;
      ST_REC:  ready = len_ok;
      ST_ADDR: ready = cancel_q && len_ok;
      ST_XFER: ready = last_beat && spec_q.write && req_write_i && len_ok;
      default: ready = 1'b0;
    endcase
  end

  assign take        = req_valid_i && ready;
  assign take_good   = take && len_ok;
  assign take_bad    = take && !len_ok;
  assign req_ready_o = ready;

  pbm_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  pbm_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .take_i   (take_good),
    .cancel_i (cancel_q),
    .ics_i    (bus_ics_i),
    .last_i   (last_beat),
    .state_o  (state_q)
  );

  pbm_req_regs #(.MAX_DB(MAX_DB)) u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .load_i   (take_good),
    .state_i  (state_q),
    .abort_i  (req_abort_i),
    .spec_i   (req_spec),
    .addr_i   (req_addr_i),
    .wdata_i  (req_wdata_i),
    .spec_o   (spec_q),
    .addr_o   (addr_q),
    .wdata_o  (wdata_q),
    .beat_o   (beat_q),
    .last_o   (last_beat),
    .cancel_o (cancel_q)
  );

  pbm_datapath #(.MAX_DB(MAX_DB)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .state_i    (state_q),
    .spec_i     (spec_q),
    .addr_i     (addr_q),
    .wdata_i    (wdata_q),
    .beat_i     (beat_q),
    .cancel_i   (cancel_q),
    .take_bad_i (take_bad),
    .ics_i      (bus_ics_i),
    .acd_i      (bus_acd_i),
    .acd_o      (bus_acd_o),
    .acd_oe_o   (bus_acd_oe_o),
    .bout_o     (bus_bout_o),
    .prq_o      (bus_prq_o),
    .rdata_o    (rsp_rdata_o),
    .done_o     (rsp_done_o),
    .err_o      (rsp_err_o),
    .cancel_o   (rsp_cancel_o)
  );
endmodule

// File: rtl/pbm_checker.sv
module pbm_checker
  import pbm_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input bus_state_e          st,
  input logic                wr,
  input logic                ics,
  input logic                prq,
  input logic [PBM_DB_W-1:0] acd,
  input logic                acd_oe,
  input logic                bout,
  input logic                done,
  input logic                err,
  input logic                req_valid,
  input logic                req_ready,
  input logic [2:0]          req_len
);

  // R1
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE || st == ST_REC) |-> (!acd_oe && !prq && !bout));

  // R3
  addr_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_FIRST) |=> (st == ST_ADDR && acd_oe && bout));

  // R4
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_WAIT && !ics) |=> (st == ST_WAIT && $stable(acd) && !prq));

  // R6
  read_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st == ST_XFER || st == ST_WAIT) && !wr) |-> (!acd_oe && !bout));

  // R7
  rec_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_REC) |=> done);

  // R9
  cancel_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_ADDR && prq) |=> ((st == ST_IDLE || st == ST_FIRST) && done && !err));

  // R10
  ovl_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_OVL) |=> (st == ST_ADDR && done));

  // R11
  reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid && req_ready && req_len > 3'd5) |=> (done && err && st == ST_IDLE && !prq));

endmodule

bind pkt_bus_master pbm_checker u_pbm_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_sync_n),
  .st        (state_q),
  .wr        (spec_q.write),
  .ics       (bus_ics_i),
  .prq       (bus_prq_o),
  .acd       (bus_acd_o),
  .acd_oe    (bus_acd_oe_o),
  .bout      (bus_bout_o),
  .done      (rsp_done_o),
  .err       (rsp_err_o),
  .req_valid (req_valid_i),
  .req_ready (req_ready_o),
  .req_len   (req_len_i)
);

// File: tb/pkt_bus_master_test.sv
module pkt_bus_master_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_other, req_write, req_rmw, req_abort;
  logic [2:0]  req_len;
  logic [1:0]  req_mode;
  logic [23:0] req_addr;
  logic [79:0] req_wdata;
  logic        ready, done, rerr, rcxl;
  logic [79:0] rdata;
  logic [15:0] acd_o, acd_i;
  logic        acd_oe, prq, bout, ics;

  int n_chk = 0;
  int n_err = 0;

  // current access as the bench sees it
  logic        c_other, c_write, c_rmw;
  logic [2:0]  c_len;
  logic [1:0]  c_mode;
  logic [23:0] c_addr;
  logic [79:0] c_wdata;
  int          c_wait [5];
  logic [79:0] exp_rd;

  always #10 clk = ~clk;

  pkt_bus_master uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(ready),
    .req_other_i(req_other), .req_write_i(req_write), .req_rmw_i(req_rmw),
    .req_len_i(req_len), .req_mode_i(req_mode), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_abort_i(req_abort),
    .rsp_done_o(done), .rsp_err_o(rerr), .rsp_cancel_o(rcxl), .rsp_rdata_o(rdata),
    .bus_acd_o(acd_o), .bus_acd_oe_o(acd_oe), .bus_acd_i(acd_i),
    .bus_prq_o(prq), .bus_bout_o(bout), .bus_ics_i(ics)
  );

  task automatic check(input string req, input string what, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] spec_exp();
    return {c_other, c_write, c_rmw, c_len, c_mode};
  endfunction

  function automatic int nbeats(input logic [2:0] len);
    return (len == 3'd0) ? 1 : int'(len);
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rand_cur(input int force_wr);
    c_other = 1'($urandom);
    c_write = (force_wr >= 0) ? 1'(force_wr) : 1'($urandom);
    c_rmw   = 1'($urandom);
    c_len   = 3'($urandom_range(0, 5));
    c_mode  = 2'($urandom);
    c_addr  = 24'($urandom);
    c_wdata = {$urandom, $urandom, 16'($urandom)};
    for (int i = 0; i < 5; i++) c_wait[i] = $urandom_range(0, 2);
  endtask

  task automatic present_cur();
    req_valid = 1'b1;
    req_other = c_other; req_write = c_write; req_rmw = c_rmw;
    req_len = c_len; req_mode = c_mode; req_addr = c_addr; req_wdata = c_wdata;
  endtask

  // current cycle is a request cycle (plain or overlapped)
  task automatic chk_first();
    check("R2", "prq", 80'(prq), 80'(1));
    check("R2", "bout", 80'(bout), 80'(1));
    check("R2", "oe", 80'(acd_oe), 80'(1));
    check("R2", "spec+addr_lo", 80'(acd_o), 80'({spec_exp(), c_addr[7:0]}));
    check("R13", "ready in request cycle", 80'(ready), 80'(0));
  endtask

  // entered at the address cycle, leaves at the last data cycle
  task automatic run_body();
    int nb;
    nb = nbeats(c_len);
    check("R3", "addr_hi", 80'(acd_o), 80'({c_addr[23:16], c_addr[15:8]}));
    check("R3", "prq", 80'(prq), 80'(0));
    check("R3", "bout", 80'(bout), 80'(1));
    check("R13", "ready in address cycle", 80'(ready), 80'(0));
    exp_rd = '0;
    ics = (c_wait[0] == 0);
    for (int b = 0; b < nb; b++) begin
      for (int k = 1; k <= c_wait[b]; k++) begin
        step();
        check("R4", "wait prq", 80'(prq), 80'(0));
        check("R4", "wait oe", 80'(acd_oe), 80'(c_write));
        if (c_write) check("R4", "wait data", 80'(acd_o), 80'(c_wdata[b*16 +: 16]));
        check("R13", "ready in wait", 80'(ready), 80'(0));
        ics = (k == c_wait[b]);
      end
      step();
      check("R5", "data prq", 80'(prq), 80'(0));
      if (c_write) begin
        check("R5", "write oe", 80'(acd_oe), 80'(1));
        check("R5", "write bout", 80'(bout), 80'(1));
        check("R5", "write beat", 80'(acd_o), 80'(c_wdata[b*16 +: 16]));
      end else begin
        logic [15:0] v;
        check("R6", "read oe", 80'(acd_oe), 80'(0));
        check("R6", "read bout", 80'(bout), 80'(0));
        v = 16'($urandom);
        acd_i = v;
        exp_rd[b*16 +: 16] = v;
      end
      if (b < nb - 1) begin
        check("R13", "ready mid data", 80'(ready), 80'(0));
        ics = (c_wait[b+1] == 0);
      end
    end
  endtask

  // from the last data cycle through the response pulse
  task automatic run_tail(input logic err, input bit chain);
    logic [79:0] old_rd;
    logic        old_read;
    old_rd = exp_rd;
    old_read = !c_write;
    step();
    check("R7", "rec prq", 80'(prq), 80'(0));
    check("R7", "rec oe", 80'(acd_oe), 80'(0));
    check("R7", "rec bout", 80'(bout), 80'(0));
    check("R7", "rec done", 80'(done), 80'(0));
    ics = err;
    if (chain) begin
      rand_cur(-1);
      present_cur();
      check("R12", "ready in recovery", 80'(ready), 80'(1));
    end
    step();
    req_valid = 1'b0;
    ics = 1'b0;
    check("R7", "done pulse", 80'(done), 80'(1));
    check("R8", "error flag", 80'(rerr), 80'(err));
    check("R7", "cancel flag", 80'(rcxl), 80'(0));
    if (old_read) check("R6", "read data", rdata, old_rd);
  endtask

  task automatic run_txn(input logic err);
    present_cur();
    check("R1", "ready idle", 80'(ready), 80'(1));
    step();
    req_valid = 1'b0;
    check("R7", "done is one cycle", 80'(done), 80'(0));
    chk_first();
    step();
    run_body();
    run_tail(err, 1'b0);
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd4711);
    rst_n = 1'b0; req_valid = 1'b0; req_abort = 1'b0; ics = 1'b0; acd_i = '0;
    req_other = 1'b0; req_write = 1'b0; req_rmw = 1'b0; req_len = '0; req_mode = '0;
    req_addr = '0; req_wdata = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    check("R1", "reset prq", 80'(prq), 80'(0));
    check("R1", "reset oe", 80'(acd_oe), 80'(0));
    check("R1", "reset bout", 80'(bout), 80'(0));
    check("R1", "reset done", 80'(done), 80'(0));
    check("R1", "reset ready", 80'(ready), 80'(1));

    // directed: five-beat write with waits
    rand_cur(1); c_len = 3'd5;
    c_wait[0] = 0; c_wait[1] = 1; c_wait[2] = 2; c_wait[3] = 0; c_wait[4] = 1;
    run_txn(1'b0);
    // single-byte read with long stretch and a bus error
    rand_cur(0); c_len = 3'd0; c_wait[0] = 2;
    run_txn(1'b1);
    // three-beat read, no waits
    rand_cur(0); c_len = 3'd3;
    for (int i = 0; i < 5; i++) c_wait[i] = 0;
    run_txn(1'b0);

    // random mix
    for (int n = 0; n < 30; n++) begin
      rand_cur(-1);
      run_txn(1'($urandom));
    end

    // R9 cancel, nothing pending
    rand_cur(-1);
    present_cur(); step(); req_valid = 1'b0; req_abort = 1'b1;
    chk_first();
    step(); req_abort = 1'b0;
    check("R9", "prq in cancelled address cycle", 80'(prq), 80'(1));
    step();
    check("R9", "cancel done", 80'(done), 80'(1));
    check("R9", "cancel flag", 80'(rcxl), 80'(1));
    check("R9", "cancel no error", 80'(rerr), 80'(0));
    check("R9", "idle after cancel oe", 80'(acd_oe), 80'(0));
    step();
    check("R9", "no data after cancel", 80'(prq), 80'(0));

    // R9 cancel with a new request taken
    rand_cur(-1);
    present_cur(); step(); req_valid = 1'b0; req_abort = 1'b1;
    step(); req_abort = 1'b0;
    check("R9", "prq cancel 2", 80'(prq), 80'(1));
    rand_cur(-1);
    present_cur();
    check("R9", "ready in cancelled address cycle", 80'(ready), 80'(1));
    step(); req_valid = 1'b0;
    check("R9", "cancel done 2", 80'(done), 80'(1));
    check("R9", "cancel flag 2", 80'(rcxl), 80'(1));
    chk_first();
    step(); run_body(); run_tail(1'b0, 1'b0);

    // R11 reject codes 6 and 7
    for (int l = 6; l < 8; l++) begin
      rand_cur(-1); c_len = 3'(l);
      present_cur();
      check("R11", "ready for illegal length", 80'(ready), 80'(1));
      step(); req_valid = 1'b0;
      check("R11", "reject done", 80'(done), 80'(1));
      check("R11", "reject error", 80'(rerr), 80'(1));
      check("R11", "reject prq", 80'(prq), 80'(0));
      step();
      check("R11", "still idle prq", 80'(prq), 80'(0));
      check("R11", "still idle oe", 80'(acd_oe), 80'(0));
    end

    // R10 overlapped write start
    rand_cur(1);
    present_cur(); step(); req_valid = 1'b0;
    chk_first(); step(); run_body();
    rand_cur(1);
    present_cur();
    check("R10", "ready on last write beat", 80'(ready), 80'(1));
    step(); req_valid = 1'b0;
    chk_first();
    check("R10", "overlap bout", 80'(bout), 80'(1));
    ics = 1'b1;
    step();
    check("R10", "previous done in address cycle", 80'(done), 80'(1));
    check("R8", "overlap recovery error", 80'(rerr), 80'(1));
    run_body(); run_tail(1'b0, 1'b0);

    // R12 back-to-back through recovery
    rand_cur(0);
    present_cur(); step(); req_valid = 1'b0;
    chk_first(); step(); run_body();
    run_tail(1'b0, 1'b1);
    check("R12", "request cycle follows recovery", 80'(prq), 80'(1));
    chk_first();
    step(); run_body(); run_tail(1'b1, 1'b0);

    step();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule